// File: doc/BRIEF.md
# Sticky Floating-Point Exception Status Register

This block collects the exception flags reported by several floating-point execution units into one status word. Each unit that finishes an operation presents a valid strobe, a one-bit guard (the least significant bit of the operation's guard register) and a six-bit flag vector. The six flags are invalid operation, overflow, underflow, inexact, input flushed to zero (a denormal operand was replaced by zero) and output flushed to zero (a denormal result was replaced by zero). A flag is set when any qualifying unit reports it, and it stays set until software writes the register. Updates from every unit that completes in a cycle are combined with the stored value in that same cycle.

Software has one write port that loads the whole word, clearing flags or setting them, and a read port that always shows the stored word. The word also holds a rounding-mode field. Software writes it and the block drives it out to the execution units. No unit update ever changes it. The update ports have no ready signal and no back-pressure. The register accepts every update in every cycle, so a producer never stalls and no update is ever dropped.

Top module: `sticky_fpx_status`

## Requirements
- R1: After reset, the read word, the flag output and the rounding-mode output are all zero.
- R2: An update whose valid and guard are both 1 sets each flag in its vector. The flag is visible on the outputs on the clock edge that follows.
- R3: A flag never goes from 1 to 0 except through a software write.
- R4: When several units update in one cycle, each stored flag becomes the OR of its previous value and the flags from all qualifying units.
- R5: An update whose guard is 0 leaves the stored flags unchanged, even if valid is 1.
- R6: An update whose valid is 0 leaves the stored flags unchanged, even if guard is 1.
- R7: A software write loads the flags from bits 5:0 of the write data and the rounding mode from bits 7:6. A write of zero with no concurrent update clears every flag.
- R8: When a software write and qualifying updates arrive in the same cycle, the stored flags become the written flags ORed with the incoming flags.
- R9: The read word shows the value stored before the current cycle's updates. Any change appears only after the next clock edge.
- R10: Unit updates never change the rounding mode. Only a software write does.
- R11: Flag bit positions, in both the flag vector and the read word, are: bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 invalid, bit 4 input flushed, bit 5 output flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid_i | input | NUM_UNITS | Per-unit completion strobe |
| upd_guard_i | input | NUM_UNITS | Per-unit guard bit; 0 cancels the update |
| upd_flags_i | input | NUM_UNITS*6 | Flag vectors, unit k in bits 6k+5:6k |
| sw_wr_en_i | input | 1 | Software write strobe |
| sw_wr_data_i | input | RM_W+6 | Write data: rounding mode above, flags in 5:0 |
| rd_data_o | output | RM_W+6 | Stored word for software reads |
| flags_o | output | 6 | Stored flags |
| rnd_mode_o | output | RM_W | Stored rounding mode |

## Verification
The bench targets a write and updates that land in the same cycle. A design that let the write win would lose the incoming flags, and a design that ORed the old value would fail to clear. It also targets updates that are valid but fail their guard, and ones that are guarded but not valid. A design that ignored either qualifier would set flags spuriously. The bench samples the read word within the update cycle itself, which catches a read path that bypasses the register. Random traffic on all five units, with writes that change the rounding mode, catches a design that drops any unit from the OR or lets updates corrupt the rounding field.

// File: rtl/fxf_pkg.sv
package fxf_pkg;
  localparam int FLAG_W = 6;
  localparam int FX_INX = 0;
  localparam int FX_UNF = 1;
  localparam int FX_OVF = 2;
  localparam int FX_INV = 3;
  localparam int FX_IFZ = 4;
  localparam int FX_OFZ = 5;
  typedef logic [FLAG_W-1:0] fx_flags_t;
endpackage

// File: rtl/fxf_gate.sv
module fxf_gate
  import fxf_pkg::*;
#(
  parameter int NUM_UNITS = 5
) (
  input  logic [NUM_UNITS-1:0]        valid_i,
  input  logic [NUM_UNITS-1:0]        guard_i,
  input  logic [NUM_UNITS*FLAG_W-1:0] flags_i,
  output fx_flags_t [NUM_UNITS-1:0]   gated_o
);
  // each unit contributes only when it completes and its guard holds
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic take;
    assign take       = valid_i[u] & guard_i[u];
    assign gated_o[u] = take ? flags_i[u*FLAG_W +: FLAG_W] : '0;
  end
endmodule

// File: rtl/fxf_or_merge.sv
module fxf_or_merge
  import fxf_pkg::*;
#(
  parameter int NUM_UNITS = 5
) (
  input  fx_flags_t [NUM_UNITS-1:0] gated_i,
  output fx_flags_t                 merged_o
);
  always_comb begin
    merged_o = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      merged_o = merged_o | gated_i[u];
    end
  end
endmodule

// File: rtl/fxf_state.sv
module fxf_state
  import fxf_pkg::*;
#(
  parameter int RM_W = 2,
  localparam int REG_W = RM_W + FLAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fx_flags_t        merged_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output fx_flags_t        flags_q,
  output logic [RM_W-1:0]  rm_q
);
  fx_flags_t       base;
  fx_flags_t       flags_d;
  logic [RM_W-1:0] rm_d;

  // a write replaces the stored base; incoming flags land on top of it
  always_comb begin
    base    = wr_en_i ? wr_data_i[FLAG_W-1:0] : flags_q;
    flags_d = base | merged_i;
    rm_d    = wr_en_i ? wr_data_i[REG_W-1:FLAG_W] : rm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      rm_q    <= '0;
    end else begin
      flags_q <= flags_d;
      rm_q    <= rm_d;
    end
  end
endmodule

// File: rtl/sticky_fpx_status.sv
module sticky_fpx_status
  import fxf_pkg::*;
#(
  parameter int NUM_UNITS = 5,
  parameter int RM_W      = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_UNITS-1:0]        upd_valid_i,
  input  logic [NUM_UNITS-1:0]        upd_guard_i,
  input  logic [NUM_UNITS*FLAG_W-1:0] upd_flags_i,
  input  logic                        sw_wr_en_i,
  input  logic [RM_W+FLAG_W-1:0]      sw_wr_data_i,
  output logic [RM_W+FLAG_W-1:0]      rd_data_o,
  output logic [FLAG_W-1:0]           flags_o,
  output logic [RM_W-1:0]             rnd_mode_o
);
  fx_flags_t [NUM_UNITS-1:0] gated;
  fx_flags_t                 merged;
  fx_flags_t                 flags_q;
  logic [RM_W-1:0]           rm_q;

  fxf_gate #(.NUM_UNITS(NUM_UNITS)) u_gate (
    .valid_i (upd_valid_i),
    .guard_i (upd_guard_i),
    .flags_i (upd_flags_i),
    .gated_o (gated)
  );

  fxf_or_merge #(.NUM_UNITS(NUM_UNITS)) u_merge (
    .gated_i  (gated),
    .merged_o (merged)
  );

  fxf_state #(.RM_W(RM_W)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .merged_i  (merged),
    .wr_en_i   (sw_wr_en_i),
    .wr_data_i (sw_wr_data_i),
    .flags_q   (flags_q),
    .rm_q      (rm_q)
  );

  // read path comes straight from the register: pre-update value
  assign rd_data_o  = {rm_q, flags_q};
  assign flags_o    = flags_q;
  assign rnd_mode_o = rm_q;
endmodule

// File: rtl/sticky_fpx_status_chk.sv
module sticky_fpx_status_chk
  import fxf_pkg::*;
#(
  parameter int NUM_UNITS = 5,
  parameter int RM_W      = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_UNITS-1:0]        upd_valid_i,
  input logic [NUM_UNITS-1:0]        upd_guard_i,
  input logic [NUM_UNITS*FLAG_W-1:0] upd_flags_i,
  input logic                        sw_wr_en_i,
  input logic [RM_W+FLAG_W-1:0]      sw_wr_data_i,
  input logic [RM_W+FLAG_W-1:0]      rd_data_o,
  input logic [FLAG_W-1:0]           flags_o,
  input logic [RM_W-1:0]             rnd_mode_o
);
  logic [FLAG_W-1:0] in_or;
  always_comb begin
    in_or = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (upd_valid_i[u] && upd_guard_i[u]) in_or = in_or | upd_flags_i[u*FLAG_W +: FLAG_W];
    end
  end

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_en_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  // R2
  upd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_o & $past(in_or)) == $past(in_or)));

  // R5
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr_en_i && in_or == '0) |=> $stable(flags_o));

  // R10
  rm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_en_i |=> $stable(rnd_mode_o));

  // R7
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_en_i && in_or == '0) |=> (rd_data_o == $past(sw_wr_data_i)));

  // R8
  wr_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en_i |=> (flags_o == ($past(sw_wr_data_i[FLAG_W-1:0]) | $past(in_or))));
endmodule

bind sticky_fpx_status sticky_fpx_status_chk #(.NUM_UNITS(NUM_UNITS), .RM_W(RM_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .upd_valid_i  (upd_valid_i),
  .upd_guard_i  (upd_guard_i),
  .upd_flags_i  (upd_flags_i),
  .sw_wr_en_i   (sw_wr_en_i),
  .sw_wr_data_i (sw_wr_data_i),
  .rd_data_o    (rd_data_o),
  .flags_o      (flags_o),
  .rnd_mode_o   (rnd_mode_o)
);

// File: tb/tb_sticky_fpx_status.sv
`timescale 1ns/1ps
module tb_sticky_fpx_status;
  localparam int N  = 5;
  localparam int FW = 6;
  localparam int RW = 2;
  localparam int WW = RW + FW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  v = '0;
  logic [N-1:0]  g = '0;
  logic [N*FW-1:0] f = '0;
  logic          we = 1'b0;
  logic [WW-1:0] wd = '0;
  logic [WW-1:0] rd;
  logic [FW-1:0] fl;
  logic [RW-1:0] rm;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [WW-1:0] exp_word = '0;

  always #2.5 clk = ~clk;

  sticky_fpx_status #(.NUM_UNITS(N), .RM_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .upd_valid_i(v), .upd_guard_i(g), .upd_flags_i(f),
    .sw_wr_en_i(we), .sw_wr_data_i(wd), .rd_data_o(rd), .flags_o(fl), .rnd_mode_o(rm)
  );

  task automatic check(input bit ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // expected next word, from the requirements
  function automatic logic [WW-1:0] next_word(input logic [WW-1:0] cur, input logic w,
      input logic [WW-1:0] d, input logic [N-1:0] vv, input logic [N-1:0] gg, input logic [N*FW-1:0] ff);
    logic [FW-1:0] acc;
    logic [RW-1:0] r;
    acc = w ? d[FW-1:0] : cur[FW-1:0];
    r   = w ? d[WW-1:FW] : cur[WW-1:FW];
    for (int k = 0; k < N; k++) if (vv[k] & gg[k]) acc |= ff[k*FW +: FW];
    return {r, acc};
  endfunction

  // drive at negedge, check pre-update read, advance one edge
  task automatic cyc(input logic [N-1:0] vv, input logic [N-1:0] gg, input logic [N*FW-1:0] ff,
                     input logic w, input logic [WW-1:0] d, input string req);
    v = vv; g = gg; f = ff; we = w; wd = d;
    #1;
    check(rd == exp_word, "R9", rd, exp_word);
    exp_word = next_word(exp_word, w, d, vv, gg, ff);
    @(posedge clk);
    @(negedge clk);
    check(rd == exp_word && fl == exp_word[FW-1:0] && rm == exp_word[WW-1:FW], req, rd, exp_word);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%02h expected=%02h", rd, exp_word);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rd == '0 && fl == '0 && rm == '0, "R1", rd, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd == '0, "R1", rd, '0);
    // R2 / R11: unit 0 reports inexact (bit 0)
    cyc(5'b00001, 5'b00001, 30'h0000_0001, 1'b0, '0, "R2");
    check(fl[0] == 1'b1, "R11", {2'b0, fl}, 8'h01);
    // R5: guard low, valid high, all flags
    cyc(5'b00010, 5'b00000, {N{6'h3f}}, 1'b0, '0, "R5");
    check(fl == 6'h01, "R5", {2'b0, fl}, 8'h01);
    // R6: valid low, guard high
    cyc(5'b00000, 5'b11111, {N{6'h3f}}, 1'b0, '0, "R6");
    check(fl == 6'h01, "R6", {2'b0, fl}, 8'h01);
    // R4: unit 2 overflow (bit 2), unit 4 invalid (bit 3) at once
    cyc(5'b10100, 5'b10100, (30'h04 << 12) | (30'h08 << 24), 1'b0, '0, "R4");
    check(fl == 6'h0d, "R4", {2'b0, fl}, 8'h0d);
    // R3: idle cycles keep flags
    cyc('0, '0, '0, 1'b0, '0, "R3");
    // R7: write rounding mode 2, flag out-flush only
    cyc('0, '0, '0, 1'b1, 8'b10_100000, "R7");
    check(rm == 2'b10, "R7", {6'b0, rm}, 8'h02);
    // R10: updates leave rounding mode alone
    cyc(5'b11111, 5'b11111, {N{6'h10}}, 1'b0, '0, "R10");
    check(rm == 2'b10, "R10", {6'b0, rm}, 8'h02);
    // R8: write zero while unit 3 reports underflow (bit 1)
    cyc(5'b01000, 5'b01000, 30'h02 << 18, 1'b1, 8'b01_000000, "R8");
    check(fl == 6'h02, "R8", {2'b0, fl}, 8'h02);
    // R7: clearing write
    cyc('0, '0, '0, 1'b1, 8'h00, "R7");
    check(rd == 8'h00, "R7", rd, 8'h00);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0]    rv, rg;
      logic [N*FW-1:0] rf;
      logic            rw;
      logic [WW-1:0]   rdat;
      rv = N'($urandom);
      rg = N'($urandom) | N'($urandom);
      for (int k = 0; k < N; k++) rf[k*FW +: FW] = FW'($urandom & $urandom & $urandom);
      rw   = ($urandom % 16) == 0;
      rdat = WW'($urandom);
      cyc(rv, rg, rf, rw, rdat, rw ? "R8" : "R4");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule